// File: doc/BRIEF.md
# Stereo Serial Audio to Parallel-Latch DAC Adapter

The adapter accepts a left-justified stereo serial audio stream made of a bit clock, a word-select line and one data line, with each channel occupying a 32-clock slot. It feeds an 18-bit two-channel DAC that has one serial data input per channel and a latch strobe that moves the shifted word to the analog output. The incoming data passes through a fixed delay of 13 bit clocks. After that delay, the top 18 bits of every sample are the last bits shifted into the DAC before the slot boundary.

The left channel is held back by one more full slot. As a result, the left and right samples of a frame shift into the DAC during the same 18 clocks, and a single shared latch pulse updates both outputs at the same instant. Low-order sample bits and padding are still shifted out, but they fall after the latch and the DAC register discards them. All registers run on the rising edge of the bit clock. The design targets a 12.288 MHz bit clock.

Top module: `audio_dac_align`

## Requirements
- R1: `dac_latch` is high for exactly one bit-clock cycle per frame. This is the cycle after the rising edge that samples bit 30 of the right slot, where bit 0 is the first bit sampled with `ws` high after `ws` was low. At all other times it is low.
- R2: After rising edge k, `dac_r_data` equals the `sdata` value sampled at edge k-12, and `dac_l_data` equals the `sdata` value sampled at edge k-44.
- R3: In the 18 cycles just before each latch cycle, `dac_l_data` carries bits 31..14 of that frame's left slot word and `dac_r_data` carries bits 31..14 of its right slot word. Both are sent MSB first and in the same cycles.
- R4: Slot bits 13..0 (the low sample bits and the padding) never appear on the data outputs within the 18 cycles before a latch, so changing them does not alter what is latched.
- R5: While `rst_n` is low at a rising edge, all delay stages and the slot counter are cleared. After that edge, `dac_l_data`, `dac_r_data` and `dac_latch` are 0.
- R6: `ws` low selects the left slot and `ws` high selects the right slot. The slot counter restarts on every `ws` change, so a stream that starts at an arbitrary phase latches correctly from the first complete right slot onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ws | input | 1 | Word select: 0 = left slot, 1 = right slot |
| sdata | input | 1 | Serial audio data, MSB first, left-justified |
| dac_l_data | output | 1 | Serial data to the left DAC channel |
| dac_r_data | output | 1 | Serial data to the right DAC channel |
| dac_latch | output | 1 | Shared latch strobe for both DAC channels |

## Verification
The latch strobe and the final MSB-aligned data bits of both channels fall in neighbouring cycles, and the slot-counter restart coincides with the first data bit of a new slot. The stimulus uses random 32-bit slot words, so the padding bits change from frame to frame. It starts each run with a word-select prefix of odd length, which misaligns the counter until the first right slot begins. At every latch, the bench compares the 18 bits each output carried in the preceding cycles with the top bits of the words it drove. It also checks the raw delay on every cycle and checks that no latch appears anywhere else.

// File: rtl/audio_dac_align.sv
module audio_dac_align #(
  parameter int SLOT  = 32,
  parameter int DEPTH = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws,
  input  logic sdata,
  output logic dac_l_data,
  output logic dac_r_data,
  output logic dac_latch
);
  localparam int PRE = SLOT - DEPTH - 1;
  localparam int LEN = SLOT + PRE;
  localparam int CW  = $clog2(SLOT);
  localparam logic [CW-1:0] LAT_AT = CW'(SLOT - 3);

  logic [LEN-1:0] chain;
  logic [CW-1:0]  cnt;
  logic           ws_q;
  logic           start;

  assign start = ws != ws_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain     <= '0;
      cnt       <= '0;
      ws_q      <= 1'b0;
      dac_latch <= 1'b0;
    end else begin
      chain     <= {chain[LEN-2:0], sdata};
      ws_q      <= ws;
      cnt       <= start ? '0 : cnt + 1'b1;
      dac_latch <= ws && !start && cnt == LAT_AT;
    end
  end

  assign dac_r_data = chain[PRE-1];
  assign dac_l_data = chain[LEN-1];

  a_r1_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    dac_latch |=> !dac_latch);

  a_r6_latch_in_right: assert property (@(posedge clk) disable iff (!rst_n)
    dac_latch |-> $past(ws));

  a_r5_reset_latch: assert property (@(posedge clk)
    !rst_n |=> !dac_latch);

  a_r5_reset_data: assert property (@(posedge clk)
    !rst_n |=> (!dac_l_data && !dac_r_data));
endmodule

// File: tb/test_audio_dac_align.sv
module test_audio_dac_align;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ws = 1'b0;
  logic sdata = 1'b0;
  logic dac_l_data, dac_r_data, dac_latch;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit hist [0:8191];
  int n = 0;
  logic [17:0] lh, rh;

  always #2.5 clk = ~clk;

  audio_dac_align i_audio_dac_align (
    .clk(clk), .rst_n(rst_n), .ws(ws), .sdata(sdata),
    .dac_l_data(dac_l_data), .dac_r_data(dac_r_data), .dac_latch(dac_latch)
  );

  function automatic logic [17:0] top18(input logic [31:0] w);
    return w[31:14];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic d, input bit lat_exp,
                      input logic [31:0] lw, input logic [31:0] rw);
    @(negedge clk);
    chk("R1 latch", {31'd0, dac_latch}, {31'd0, lat_exp});
    if (lat_exp) begin
      chk("R3 left msbs", {14'd0, lh}, {14'd0, top18(lw)});
      chk("R3 right msbs", {14'd0, rh}, {14'd0, top18(rw)});
      chk("R4 left low bits excluded", {14'd0, lh}, {14'd0, lw[31:14]});
    end
    if (n >= 13) chk("R2 right delay", {31'd0, dac_r_data}, {31'd0, hist[n-13]});
    if (n >= 45) chk("R2 left delay", {31'd0, dac_l_data}, {31'd0, hist[n-45]});
    lh = {lh[16:0], dac_l_data};
    rh = {rh[16:0], dac_r_data};
    ws = w;
    sdata = d;
    hist[n] = d;
    n++;
  endtask

  task automatic run(input int prefix, input int frames);
    logic [31:0] lw, rw;
    n = 0;
    for (int i = 0; i < prefix; i++) step(1'b1, 1'($urandom), 1'b0, 0, 0);
    for (int f = 0; f < frames; f++) begin
      lw = $urandom;
      rw = $urandom;
      if (f == 0) begin lw = 32'h8000_0001; rw = 32'h7FFF_C000; end
      if (f == 1) begin lw = 32'h0000_3FFF; rw = 32'hFFFF_C000; end
      for (int b = 0; b < 32; b++) step(1'b0, lw[31-b], 1'b0, lw, rw);
      for (int b = 0; b < 32; b++) step(1'b1, rw[31-b], b == 31, lw, rw);
    end
  endtask

  initial begin
    void'($urandom(32'd1865));
    repeat (3) @(negedge clk);
    chk("R5 reset latch", {31'd0, dac_latch}, 32'd0);
    chk("R5 reset left", {31'd0, dac_l_data}, 32'd0);
    chk("R5 reset right", {31'd0, dac_r_data}, 32'd0);
    rst_n = 1'b1;
    run(7, 40);
    ws = 1'b1;
    sdata = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 mid reset latch", {31'd0, dac_latch}, 32'd0);
    chk("R5 mid reset left", {31'd0, dac_l_data}, 32'd0);
    chk("R5 mid reset right", {31'd0, dac_r_data}, 32'd0);
    rst_n = 1'b1;
    run(13, 30);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule